// File: doc/BRIEF.md
# SIMD Absolute-Value Sum Unit

This unit executes one vector instruction over a 256-bit datapath. For every element it adds the absolute values of the matching elements of two source vectors. The elements are treated as signed two's-complement numbers. A 2-bit field in the 32-bit instruction word sets the element width to 8, 16, 32 or 64 bits. The same adder fabric is split into 32, 16, 8 or 4 independent lanes to match.

The unit decodes the two source register indices from the instruction word without a clock edge, so the surrounding register file can supply both operands in the same cycle. The instruction and its operands enter on a valid/ready handshake and sit in a one-entry output register until the consumer takes them. A word that does not belong to this instruction family produces no result. It raises a one-cycle illegal flag instead.

Handshake rules:
- Input side: a beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle.
- Output side: a held result and its destination index stay unchanged for as long as `out_valid` is high and `out_ready` is low.

Top module: `simd_absadd_unit`

## Requirements
- R1: A word matches the family only when bits [31:17] equal 15'b011101000101110. Bits [16:15] carry the size code.
- R2: The size code maps to element widths as follows: 2'b00 gives 8-bit elements (32 lanes), 2'b01 gives 16-bit (16 lanes), 2'b10 gives 32-bit (8 lanes) and 2'b11 gives 64-bit (4 lanes). Lane i occupies bits [i*w +: w].
- R3: Each result lane equals abs(src_a lane) + abs(src_b lane), with both lanes read as signed two's complement.
- R4: Each lane sum wraps modulo 2^w. No carry passes into the neighbouring lane and no saturation is applied.
- R5: The absolute value of the most negative lane value (only the sign bit set) keeps the same bit pattern. That pattern then enters the wrapping add unchanged.
- R6: Without a clock edge, `src_a_idx` is insn[9:5] and `src_b_idx` is insn[14:10]. `out_dst` is registered from insn[4:0] of the accepted word.
- R7: Reset, which is synchronous and active high, clears `out_valid` and `illegal`. An accepted matching word gives `out_valid` high with its result on the next cycle.
- R8: An accepted word that does not match raises `illegal` on the next cycle for exactly one cycle. In that cycle `out_valid` is low.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_dst` hold their values. A beat offered during that time is not taken.
- R10: `illegal` is high only in the cycle after an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction beat offered |
| in_ready | output | 1 | Unit can accept a beat |
| insn | input | 32 | Instruction word |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| src_a_idx | output | 5 | First source register index, decoded without a clock edge |
| src_b_idx | output | 5 | Second source register index, decoded without a clock edge |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Lane-wise absolute-value sum |
| out_dst | output | 5 | Destination register index |
| illegal | output | 1 | One-cycle flag for an accepted non-matching word |

## Verification
Draining a stalled result and detecting an illegal word can happen in the same cycle. To provoke this, the bench holds a result with `out_ready` low, then raises `out_ready` in the same cycle that it offers a non-matching word. On the next cycle the bench expects `illegal` high, `out_valid` low and no trace of the old result. A legal word is also offered while the output stalls, and the bench checks that it is taken only when the stall ends and that the held result never changes during the stall.

// File: rtl/simd_absadd_pkg.sv
package simd_absadd_pkg;
  localparam int VEC_W     = 256;
  localparam int INSN_W    = 32;
  localparam int IDX_W     = 5;
  localparam int NUM_SIZES = 4;
  localparam int FAMILY_W  = 15;
  localparam logic [FAMILY_W-1:0] FAMILY_CODE = 15'b011101000101110;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } elem_size_e;

  typedef struct packed {
    logic             match;
    elem_size_e       size;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] srca;
    logic [IDX_W-1:0] srcb;
  } decoded_t;
endpackage

// File: rtl/simd_absadd_decode.sv
module simd_absadd_decode
  import simd_absadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output decoded_t          dec
);
  always_comb begin
    dec.match = (insn[INSN_W-1 -: FAMILY_W] == FAMILY_CODE);
    dec.size  = elem_size_e'(insn[16:15]);
    dec.srcb  = insn[14:10];
    dec.srca  = insn[9:5];
    dec.dst   = insn[4:0];
  end
endmodule

// File: rtl/simd_abs_wrap.sv
module simd_abs_wrap #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  // Two's-complement negate for negative inputs; the most negative value maps to itself.
  assign y = x[W-1] ? (~x + W'(1)) : x;
endmodule

// File: rtl/simd_absadd_lanes.sv
module simd_absadd_lanes #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] sum
);
  localparam int LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mag_a, mag_b;
    simd_abs_wrap #(.W(LANE_W)) u_abs_a (.x(a[i*LANE_W +: LANE_W]), .y(mag_a));
    simd_abs_wrap #(.W(LANE_W)) u_abs_b (.x(b[i*LANE_W +: LANE_W]), .y(mag_b));
    // Sum truncated to the lane: wraps, no carry out of the lane.
    assign sum[i*LANE_W +: LANE_W] = mag_a + mag_b;
  end
endmodule

// File: rtl/simd_absadd_unit.sv
module simd_absadd_unit
  import simd_absadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  output logic [IDX_W-1:0]  src_a_idx,
  output logic [IDX_W-1:0]  src_b_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data,
  output logic [IDX_W-1:0]  out_dst,
  output logic              illegal
);
  decoded_t         dec;
  logic [VEC_W-1:0] per_size [NUM_SIZES];
  logic [VEC_W-1:0] result;
  logic             accept;

  simd_absadd_decode u_dec (.insn(insn), .dec(dec));

  // One lane array per element width; lane width = 8 << k.
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    simd_absadd_lanes #(.VEC_W(VEC_W), .LANE_W(8 << k)) u_lanes (
      .a(src_a), .b(src_b), .sum(per_size[k])
    );
  end

  always_comb begin
    unique case (dec.size)
      SZ_BYTE: result = per_size[0];
      SZ_HALF: result = per_size[1];
      SZ_WORD: result = per_size[2];
      default: result = per_size[3];
    endcase
  end

  assign src_a_idx = dec.srca;
  assign src_b_idx = dec.srcb;
  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      illegal <= accept && !dec.match;
      if (accept)         out_valid <= dec.match;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && dec.match) begin
      out_data <= result;
      out_dst  <= dec.dst;
    end
  end
endmodule

// File: rtl/simd_absadd_unit_chk.sv
module simd_absadd_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [31:0]  insn,
  input logic         out_valid,
  input logic         out_ready,
  input logic [255:0] out_data,
  input logic [4:0]   out_dst,
  input logic         illegal
);
  logic fam_hit;
  assign fam_hit = (insn[31:17] == 15'b011101000101110);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dst)));

  p_accept_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && fam_hit) |=> out_valid);

  p_dst_field_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && fam_hit) |=> (out_dst == $past(insn[4:0])));

  p_illegal_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !fam_hit) |=> (illegal && !out_valid));

  p_illegal_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !illegal);
endmodule

bind simd_absadd_unit simd_absadd_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .insn(insn),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_dst(out_dst), .illegal(illegal)
);

// File: tb/simd_absadd_unit_test.sv
module simd_absadd_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  insn = '0;
  logic [255:0] src_a = '0, src_b = '0;
  logic [4:0]   src_a_idx, src_b_idx;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic [4:0]   out_dst;
  logic         illegal;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  simd_absadd_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .insn(insn),
    .src_a(src_a), .src_b(src_b), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dst(out_dst), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [4:0] d,
                                     input logic [4:0] sa, input logic [4:0] sb);
    return {15'b011101000101110, sz, sb, sa, d};
  endfunction

  function automatic logic [255:0] ref_sum(input logic [1:0] sz, input logic [255:0] a,
                                           input logic [255:0] b);
    int w = 8 << sz;
    logic [255:0] mask = (256'd1 << w) - 256'd1;
    logic [255:0] r = '0;
    for (int i = 0; i < 256 / w; i++) begin
      logic [255:0] ea = (a >> (i * w)) & mask;
      logic [255:0] eb = (b >> (i * w)) & mask;
      if (ea[w-1]) ea = (~ea + 256'd1) & mask;
      if (eb[w-1]) eb = (~eb + 256'd1) & mask;
      r |= ((ea + eb) & mask) << (i * w);
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [255:0] fill(input logic [1:0] sz, input logic [63:0] pat);
    int w = 8 << sz;
    logic [255:0] r = '0;
    for (int i = 0; i < 256 / w; i++) r |= (256'(pat) & ((256'd1 << w) - 256'd1)) << (i * w);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, accept at posedge, sample at following negedge.
  task automatic run_op(input logic [1:0] sz, input logic [255:0] a, input logic [255:0] b,
                        input logic [4:0] d, input string req);
    logic [255:0] exp = ref_sum(sz, a, b);
    insn = mk(sz, d, 5'(d + 5'd3), 5'(d + 5'd7));
    src_a = a; src_b = b; in_valid = 1'b1;
    #1;
    check(src_a_idx == 5'(d + 5'd3) && src_b_idx == 5'(d + 5'd7), "R6 src idx",
          {src_a_idx, src_b_idx}, {5'(d + 5'd3), 5'(d + 5'd7)});
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && illegal === 1'b0, "R7 valid", {out_valid, illegal}, 2'b10);
    check(out_data === exp, req, out_data, exp);
    check(out_dst === d, "R6 dst", out_dst, d);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && illegal === 1'b0, "R7 reset", {out_valid, illegal}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: most negative lane values pass through unchanged when added to zero.
    for (int s = 0; s < 4; s++)
      run_op(2'(s), fill(2'(s), 64'h8000_0000_0000_0000 >> (64 - (8 << s))), '0, 5'(s), "R5 min neg");
    // R4: wrap inside the lane, no carry across lanes.
    for (int s = 0; s < 4; s++) begin
      logic [63:0] mn = 64'h8000_0000_0000_0000 >> (64 - (8 << s));
      run_op(2'(s), fill(2'(s), mn), fill(2'(s), mn), 5'(s + 8), "R4 wrap");
      run_op(2'(s), fill(2'(s), mn - 64'd1), fill(2'(s), mn - 64'd1), 5'(s + 12), "R4 max pos");
    end
    // R3: all-ones (-1) in every lane gives 2 per lane.
    for (int s = 0; s < 4; s++)
      run_op(2'(s), '1, '1, 5'(s + 20), "R3 minus one");
    // R2 / R3: random operands across all size codes.
    for (int n = 0; n < 200; n++)
      run_op(2'(n % 4), rnd256(), rnd256(), 5'($urandom()), "R2 R3 random");

    // R1 / R8 / R10: a non-matching word raises illegal for one cycle.
    insn = mk(2'b00, 5'd1, 5'd2, 5'd3) ^ 32'h0010_0000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(illegal === 1'b1 && out_valid === 1'b0, "R1 R8 illegal", {illegal, out_valid}, 2'b10);
    @(negedge clk);
    check(illegal === 1'b0, "R10 pulse", illegal, 0);

    // R9: back-pressure holds the result and blocks a second beat.
    out_ready = 1'b0;
    begin
      logic [255:0] a1 = rnd256(), b1 = rnd256(), a2 = rnd256(), b2 = rnd256();
      logic [255:0] e1 = ref_sum(2'b01, a1, b1), e2 = ref_sum(2'b10, a2, b2);
      insn = mk(2'b01, 5'd9, 5'd0, 5'd0); src_a = a1; src_b = b1; in_valid = 1'b1;
      @(negedge clk);
      insn = mk(2'b10, 5'd17, 5'd0, 5'd0); src_a = a2; src_b = b2;
      check(in_ready === 1'b0, "R9 ready low", in_ready, 0);
      repeat (3) begin
        @(negedge clk);
        check(out_valid === 1'b1 && out_data === e1 && out_dst === 5'd9, "R9 hold", out_data, e1);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_data === e2 && out_dst === 5'd17 && out_valid === 1'b1, "R9 second beat", out_data, e2);

      // Drain of a stalled result coincides with an illegal word.
      out_ready = 1'b0;
      insn = mk(2'b11, 5'd4, 5'd0, 5'd0); src_a = a1; src_b = b1; in_valid = 1'b1;
      @(negedge clk);
      out_ready = 1'b1;
      insn = 32'hFFFF_FFFF;
      @(negedge clk);
      in_valid = 1'b0;
      check(illegal === 1'b1 && out_valid === 1'b0, "R8 drain plus illegal",
            {illegal, out_valid}, 2'b10);
    end

    // R7: reset clears a pending result.
    out_ready = 1'b0;
    insn = mk(2'b00, 5'd2, 5'd0, 5'd0); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && illegal === 1'b0, "R7 reset clears", {out_valid, illegal}, 0);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule